// File: doc/BRIEF.md
# Two-Wire Slave Memory Port

This block is the slave side of a two-wire serial bus, in the style of I2C, placed in front of a 256-byte memory. It runs on a system clock that is at least eight times faster than the bus clock. Both bus lines are sampled through a synchronizer, and START and STOP are found from edges of the sampled lines. The block compares the device byte with a fixed four-bit prefix and three strap pins. It pulls SDA low only through an open-drain output enable.

A write carries a word address and then any number of data bytes. Each data byte leaves the block as a one-cycle write strobe to an external commit engine. A STOP that ends such a write produces a commit pulse. While the commit engine reports busy, the slave does not acknowledge its device byte, so the master can poll until the slave answers. Reads fetch bytes through a read strobe. The block keeps a word pointer that survives between transactions, so it supports current-address, random and sequential reads. The pointer wraps from FFh to 00h.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset the slave is idle with SDA released and no strobe active. A START (SDA falls while SCL is high) in any state aborts the current transfer and starts reception of a device byte. A STOP (SDA rises while SCL is high) returns the slave to idle.
- R2: The device byte arrives MSB first as prefix 1010, then strap bits 2..0, then the direction bit (1 = read, 0 = write). The slave acknowledges it only when prefix and strap bits match. On a mismatch it gives no acknowledge and ignores every bit until the next START.
- R3: Bits are taken on SCL rising edges. The slave changes SDA only while SCL is low, after a falling edge. It releases its acknowledge at the SCL fall that ends the ninth clock.
- R4: In a write, the first byte after the device byte loads the word pointer and is acknowledged. Each later byte is acknowledged and gives one single-cycle write strobe at the pointer address, and then the pointer advances by one.
- R5: A STOP after a write in which at least one data byte was acknowledged gives a one-cycle commit pulse. A STOP after a read, or after a write that carried only the word address, gives none.
- R6: A read that starts with a read-addressed device byte returns the byte at the word pointer. The pointer then holds the last accessed address plus one.
- R7: A write of only the word address, followed by a repeated START and a read-addressed device byte, returns the byte at that word address.
- R8: In a read, each master acknowledge (SDA low in the ninth clock) fetches and sends the next byte. The address wraps from FFh to 00h. A master NACK ends the read with no further fetch.
- R9: While busy_i is high when a device byte completes, the slave does not acknowledge it. When busy_i is low, it acknowledges normally.
- R10: A START in the middle of a data byte discards the partial byte: no write strobe is issued and the word pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_i | input | 3 | Device address strap pins |
| busy_i | input | 1 | Commit engine write cycle in progress |
| mem_addr_o | output | 8 | Memory address for a strobe |
| mem_wdata_o | output | 8 | Write data for a write strobe |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_rd_o | output | 1 | One-cycle read strobe; data expected the next cycle |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_rd_o |
| commit_o | output | 1 | One-cycle pulse when a STOP ends a write with data |

## Verification
The bench builds the block with its default prefix 1010 and two synchronizer stages, and ties the strap pins to 101. With the default 8-bit pointer, a page write and a sequential read that both cross FFh to 00h can be run, and the carried-over pointer can then be seen through a later current-address read. Each SCL half period is eight system clocks. This leaves room for the three-cycle synchronizer and edge delay before SDA is sampled, so the bench can check acknowledge release in the middle of the low phase.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WADR,
    ST_ACK_WADR,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_MACK
  } state_e;
endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // conditions only count while SCL stays high across both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_addr_ptr.sv
`timescale 1ns/1ps
module tw_addr_ptr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= ptr_q + W'(1);  // natural wrap at all-ones
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tw_tx_shift.sv
`timescale 1ns/1ps
module tw_tx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/twowire_mem_slave.sv
`timescale 1ns/1ps
module twowire_mem_slave
  import tw_pkg::*;
#(
  parameter logic [3:0]  DEV_PREFIX  = 4'b1010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              commit_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

  logic sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  state_e                st_q;
  logic [BIT_CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0]     rx_q;
  logic                  rw_q, oe_q, dirty_q, mack_q;
  logic                  wr_q, rd_q, rd_d_q, commit_q;
  logic [ADDR_W-1:0]     maddr_q;
  logic [BYTE_W-1:0]     wdata_q;

  logic                  byte_done, rx_state, dev_hit;
  logic                  ptr_load, wr_go, rd_go, tx_shift, tx_msb;
  logic [ADDR_W-1:0]     ptr;

  assign byte_done = (cnt_q == LAST_BIT);
  assign rx_state  = (st_q == ST_DEV) || (st_q == ST_WADR) || (st_q == ST_WDAT);
  assign dev_hit   = (rx_q[7:4] == DEV_PREFIX) && (rx_q[3:1] == strap_i) && !busy_i;

  assign ptr_load = (st_q == ST_WADR) && scl_fall_w && byte_done;
  assign wr_go    = (st_q == ST_WDAT) && scl_fall_w && byte_done;
  assign rd_go    = ((st_q == ST_DEV) && scl_fall_w && byte_done && dev_hit && rx_q[0]) ||
                    ((st_q == ST_MACK) && scl_rise_w && !sda_s);
  assign tx_shift = scl_fall_w && (((st_q == ST_ACK_DEV) && rw_q) ||
                                   ((st_q == ST_RDAT) && !byte_done) ||
                                   ((st_q == ST_MACK) && mack_q));

  tw_addr_ptr #(.W(ADDR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (rx_q[ADDR_W-1:0]),
    .inc_i      (wr_go | rd_go),
    .ptr_o      (ptr)
  );

  tw_tx_shift #(.W(BYTE_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_d_q),
    .load_val_i (mem_rdata_i),
    .shift_i    (tx_shift),
    .msb_o      (tx_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      dirty_q <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_w) begin
      st_q    <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      dirty_q <= 1'b0;
    end else if (stop_w) begin
      st_q    <= ST_IDLE;
      oe_q    <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (rx_state && scl_rise_w && !byte_done) begin
        rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
        cnt_q <= cnt_q + 1'b1;
      end
      case (st_q)
        ST_DEV: if (scl_fall_w && byte_done) begin
          cnt_q <= '0;
          if (dev_hit) begin
            oe_q <= 1'b1;
            rw_q <= rx_q[0];
            st_q <= ST_ACK_DEV;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_WADR: if (scl_fall_w && byte_done) begin
          cnt_q <= '0;
          oe_q  <= 1'b1;
          st_q  <= ST_ACK_WADR;
        end
        ST_WDAT: if (scl_fall_w && byte_done) begin
          cnt_q   <= '0;
          oe_q    <= 1'b1;
          dirty_q <= 1'b1;
          st_q    <= ST_ACK_WDAT;
        end
        ST_ACK_DEV: if (scl_fall_w) begin
          cnt_q <= '0;
          if (rw_q) begin
            oe_q <= ~tx_msb;
            st_q <= ST_RDAT;
          end else begin
            oe_q <= 1'b0;
            st_q <= ST_WADR;
          end
        end
        ST_ACK_WADR, ST_ACK_WDAT: if (scl_fall_w) begin
          cnt_q <= '0;
          oe_q  <= 1'b0;
          st_q  <= ST_WDAT;
        end
        ST_RDAT: begin
          if (scl_rise_w && !byte_done) cnt_q <= cnt_q + 1'b1;
          if (scl_fall_w) begin
            if (byte_done) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              oe_q <= ~tx_msb;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_w) mack_q <= ~sda_s;
          if (scl_fall_w) begin
            cnt_q <= '0;
            if (mack_q) begin
              oe_q <= ~tx_msb;
              st_q <= ST_RDAT;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      rd_d_q   <= 1'b0;
      commit_q <= 1'b0;
      maddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      wr_q     <= wr_go;
      rd_q     <= rd_go;
      rd_d_q   <= rd_q;
      commit_q <= stop_w & dirty_q;
      if (wr_go | rd_go) maddr_q <= ptr;
      if (wr_go)         wdata_q <= rx_q;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_wr_o    = wr_q;
  assign mem_rd_o    = rd_q;
  assign commit_o    = commit_q;
endmodule

// File: rtl/tw_mem_slave_chk.sv
`timescale 1ns/1ps
module tw_mem_slave_chk
  import tw_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   scl_i,
  input logic   sda_oe_o,
  input logic   busy_i,
  input logic   mem_wr_o,
  input logic   mem_rd_o,
  input logic   commit_o,
  input logic   stop_i,
  input state_e st_i
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_o && mem_rd_o));  // R4
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);  // R4
  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_i));  // R5
  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && st_i == ST_ACK_DEV) |-> !$past(busy_i));  // R9
  AST_MACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_MACK) |-> !sda_oe_o);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_o);  // R2
endmodule

bind twowire_mem_slave tw_mem_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .busy_i   (busy_i),
  .mem_wr_o (mem_wr_o),
  .mem_rd_o (mem_rd_o),
  .commit_o (commit_o),
  .stop_i   (stop_w),
  .st_i     (st_q)
);

// File: tb/twowire_mem_slave_bench.sv
`timescale 1ns/1ps
module twowire_mem_slave_bench;
  localparam int H  = 8;
  localparam int HQ = H / 2;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, mem_wr, mem_rd, commit;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_bus;
  logic [7:0] mem [256];
  int n_chk = 0, n_err = 0, wr_cnt = 0, commit_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twowire_mem_slave u_twowire_mem_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .strap_i     (STRAP),
    .busy_i      (busy),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_wr_o    (mem_wr),
    .mem_rd_o    (mem_rd),
    .mem_rdata_i (mem_rdata),
    .commit_o    (commit)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      mem_rdata  <= '0;
      wr_cnt     <= 0;
      commit_cnt <= 0;
    end else begin
      if (mem_wr) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (commit) commit_cnt <= commit_cnt + 1;
    end
  end

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wait_n(HQ); sda_m = b; wait_n(H - HQ);
    scl_m = 1'b1; wait_n(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wait_n(HQ); sda_m = 1'b1; wait_n(H - HQ);
    scl_m = 1'b1; wait_n(H / 2); b = sda_bus; wait_n(H - H / 2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wait_n(HQ); sda_m = 1'b1; wait_n(H - HQ);
    scl_m = 1'b1; wait_n(H); sda_m = 1'b0; wait_n(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(HQ); sda_m = 1'b0; wait_n(H - HQ);
    scl_m = 1'b1; wait_n(H); sda_m = 1'b1; wait_n(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_in(s);
      b[i] = s;
    end
    bit_out(~mack);
  endtask

  task automatic t_reset();
    chk("R1 reset oe", int'(sda_oe), 0);
    chk("R1 reset wr", int'(mem_wr), 0);
    chk("R1 reset rd", int'(mem_rd), 0);
    chk("R1 reset commit", int'(commit), 0);
  endtask

  task automatic t_byte_write();
    logic a;
    int c0 = commit_cnt, w0 = wr_cnt;
    bus_start();
    send_byte(DEV_W, a);      chk("R2 dev ack", int'(a), 1);
    wait_n(HQ);               chk("R3 ack released after ninth clock", int'(sda_oe), 0);
    send_byte(8'h10, a);      chk("R4 word addr ack", int'(a), 1);
    send_byte(8'h3C, a);      chk("R4 data ack", int'(a), 1);
    bus_stop(); wait_n(4);
    chk("R4 mem[10]", int'(mem[8'h10]), 'h3C);
    chk("R4 one strobe", wr_cnt - w0, 1);
    chk("R5 commit after write", commit_cnt - c0, 1);
  endtask

  task automatic t_page_wrap();
    logic a;
    int c0 = commit_cnt;
    bus_start();
    send_byte(DEV_W, a);      chk("R2 dev ack page", int'(a), 1);
    send_byte(8'hFE, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);      chk("R4 third data ack", int'(a), 1);
    bus_stop(); wait_n(4);
    chk("R4 mem[FE]", int'(mem[8'hFE]), 'h11);
    chk("R8 wrap mem[FF]", int'(mem[8'hFF]), 'h22);
    chk("R8 wrap mem[00]", int'(mem[8'h00]), 'h33);
    chk("R5 commit page", commit_cnt - c0, 1);
  endtask

  task automatic t_random_seq();
    logic a;
    logic [7:0] d;
    int c0 = commit_cnt;
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'hFE, a);      chk("R7 dummy addr ack", int'(a), 1);
    bus_start();
    send_byte(DEV_R, a);      chk("R7 read dev ack", int'(a), 1);
    recv_byte(d, 1'b1);       chk("R7 random byte", int'(d), 'h11);
    recv_byte(d, 1'b1);       chk("R8 seq byte FF", int'(d), 'h22);
    recv_byte(d, 1'b0);       chk("R8 seq wrap 00", int'(d), 'h33);
    wait_n(HQ);               chk("R8 released after nack", int'(sda_oe), 0);
    bus_stop(); wait_n(4);
    chk("R5 no commit for read", commit_cnt - c0, 0);
  endtask

  task automatic t_current();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(DEV_R, a);      chk("R6 dev ack", int'(a), 1);
    recv_byte(d, 1'b0);       chk("R6 current address byte", int'(d), int'(init_val(1)));
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'hA6, a);      chk("R2 strap mismatch nack", int'(a), 0);
    send_byte(DEV_W, a);      chk("R2 ignored until START", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'h2A, a);      chk("R2 prefix mismatch nack", int'(a), 0);
    bus_stop();
  endtask

  task automatic t_busy();
    logic a;
    logic [7:0] d;
    busy = 1'b1;
    bus_start();
    send_byte(DEV_W, a);      chk("R9 no ack while busy", int'(a), 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(DEV_R, a);      chk("R9 ack after busy", int'(a), 1);
    recv_byte(d, 1'b0);       chk("R9 read after poll", int'(d), int'(init_val(2)));
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    int w0 = wr_cnt, c0 = commit_cnt;
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'h20, a);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_start();
    send_byte(DEV_R, a);      chk("R1 restart after abort", int'(a), 1);
    recv_byte(d, 1'b0);       chk("R10 pointer unchanged", int'(d), int'(init_val('h20)));
    bus_stop(); wait_n(4);
    chk("R10 no strobe for partial byte", wr_cnt - w0, 0);
    chk("R10 mem[20] intact", int'(mem[8'h20]), int'(init_val('h20)));
    chk("R5 no commit after abort", commit_cnt - c0, 0);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_random_seq();
    t_current();
    t_mismatch();
    t_busy();
    t_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule